// File: doc/BRIEF.md
# Externally Clocked Serial Transmitter

This block sends bytes as a synchronous serial stream whose bit clock comes from outside the chip. The host writes a byte into a one-entry holding register. The block moves that byte into an internal shifter, raises a one-cycle interrupt pulse to say the holding register is free again, and drives one data bit out for each falling edge it sees on the external clock pin. A receiver on the far side samples the data on the rising edges.

The external clock is asynchronous to the system clock. It passes through a flop synchroniser, and its edges are found from the synchronised samples. While the holding register is occupied, frames follow each other with no idle bit between them. The next byte moves across on the rising edge that closes bit 7. If no byte is waiting at that point, the output stops and holds its last bit until the host writes again. The holding register has room for one byte only, so a second write before the hand-off replaces the first.

Top module: `extx_ser_tx`

## Requirements
- R1: While reset is asserted and after its release with no write, `tx_out` is 1, `buf_full` is 0 and `txi` is 0.
- R2: A `wr_en` pulse sets `buf_full` at the next clock edge. If the shifter is idle, the byte moves into it on the edge after that: `buf_full` returns to 0 and `txi` is 1 in the same cycle. This is well inside a five-cycle margin before the first external edge.
- R3: `tx_out` changes only on the third system clock edge after a falling transition of `ext_sclk` is first sampled. Two edges come from the synchroniser flops and one from the output register. It never changes at any other time.
- R4: Each frame is 8 bits, sent least significant bit first. Bit k (k = 0..7) is driven after the (k+1)-th falling edge of the frame and stays valid through the rising edge that follows it.
- R5: If a byte is waiting when the rising edge that ends bit 7 is detected, that byte is transferred at that moment. Its bit 0 then goes out on the very next falling edge, so there is no gap between frames.
- R6: A byte written during the low phase of bit 7 is still chained into the following frame, provided the high phase of bit 7 lasts at least four system clock cycles.
- R7: If no byte is waiting when bit 7 ends, transmission stops. `tx_out` holds the value of bit 7, and further external clock edges change neither `tx_out` nor `txi` until the next write.
- R8: A write while `buf_full` is 1 overwrites the held byte. Only the most recent byte is sent, and the transfer produces a single `txi` pulse.
- R9: `txi` is high for exactly one cycle per transfer, and only when a byte was held in the cycle before. `buf_full` is 0 in that cycle unless a write arrived in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| ext_sclk | input | 1 | External bit clock, asynchronous, idle high |
| tx_out | output | 1 | Serial data, changes after falling edges |
| buf_full | output | 1 | Holding register occupied |
| txi | output | 1 | One-cycle pulse when the held byte moves to the shifter |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2. With those values the three-cycle output latency after a falling edge can be counted exactly. The tightest legal external timing can also be driven: a four-cycle low phase and a bit-7 high phase of exactly four cycles. A table of six bytes runs as one unbroken stream, with each next byte written at a different bit position, including the low phase of bit 7. Directed tests then cover the stop on an empty register, extra clocks while idle, and overwrite of the held byte.

// File: rtl/extx_pkg.sv
package extx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_LAST  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/extx_edge_sync.sv
module extx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              lvl;

  assign lvl = chain_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = pin;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], pin};
    end
  endgenerate

  // idle level of the external clock is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= lvl;
    end
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/extx_hold_reg.sv
module extx_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] hold_data,
  output logic          full
);
  logic          full_d;
  logic [DW-1:0] data_d;

  // a write wins over a same-cycle take: the shifter gets the old byte
  always_comb begin
    full_d = full;
    data_d = hold_data;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_data <= '0;
    end else begin
      full      <= full_d;
      hold_data <= data_d;
    end
  end
endmodule

// File: rtl/extx_shifter.sv
module extx_shifter
  import extx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          full,
  input  logic [DW-1:0] hold_data,
  output logic          take,
  output logic          txi,
  output logic          tx_out
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  tx_state_e     state_q, state_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tx_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    tx_d    = tx_out;
    take    = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (full) begin
          take    = 1'b1;
          sh_d    = hold_data;
          cnt_d   = '0;
          state_d = TX_SHIFT;
        end
      end
      TX_SHIFT: begin
        if (fall) begin
          tx_d = sh_q[0];
          sh_d = sh_q >> 1;
          if (cnt_q == LAST_IDX) state_d = TX_LAST;
          else                   cnt_d   = cnt_q + 1'b1;
        end
      end
      TX_LAST: begin
        // hand-off point: rising edge that closes the last bit
        if (rise) begin
          if (full) begin
            take    = 1'b1;
            sh_d    = hold_data;
            cnt_d   = '0;
            state_d = TX_SHIFT;
          end else begin
            state_d = TX_IDLE;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      tx_out  <= 1'b1;
      txi     <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      tx_out  <= tx_d;
      txi     <= take;
    end
  end
endmodule

// File: rtl/extx_ser_tx.sv
module extx_ser_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_sclk,
  output logic              tx_out,
  output logic              buf_full,
  output logic              txi
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              take;
  logic [DATA_W-1:0] hold_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  extx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin   (ext_sclk),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  extx_hold_reg #(.DW(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (take),
    .hold_data (hold_data),
    .full      (buf_full)
  );

  extx_shifter #(.DW(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .full      (buf_full),
    .hold_data (hold_data),
    .take      (take),
    .txi       (txi),
    .tx_out    (tx_out)
  );
endmodule

// File: rtl/extx_ser_tx_chk.sv
module extx_ser_tx_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic ext_sclk,
  input logic tx_out,
  input logic buf_full,
  input logic txi
);
  a_r2_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> buf_full);

  a_r9_txi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    txi |=> !txi);

  a_r9_txi_empties: assert property (@(posedge clk) disable iff (!rst_n)
    txi |-> (!buf_full || $past(wr_en)));

  a_r9_txi_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    txi |-> $past(buf_full));

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      // R3: output moves only three edges after the pin was seen falling
      a_r3_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_out) |-> (!$past(ext_sclk, 3) && $past(ext_sclk, 4)));
    end
  endgenerate
endmodule

bind extx_ser_tx extx_ser_tx_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .ext_sclk (ext_sclk),
  .tx_out   (tx_out),
  .buf_full (buf_full),
  .txi      (txi)
);

// File: tb/extx_ser_tx_tb.sv
module extx_ser_tx_tb;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       ext_sclk;
  logic       tx_out;
  logic       buf_full;
  logic       txi;

  int n_chk  = 0;
  int n_fail = 0;
  int txi_cnt = 0;

  // {byte, bit position in previous frame at which it is written}
  localparam logic [10:0] VEC [0:5] = '{
    {8'hA5, 3'd0},
    {8'h3C, 3'd7},
    {8'h01, 3'd0},
    {8'hFE, 3'd7},
    {8'h96, 3'd4},
    {8'h4B, 3'd7}
  };

  extx_ser_tx #(.DATA_W(8), .SYNC_STAGES(2)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ext_sclk (ext_sclk),
    .tx_out   (tx_out),
    .buf_full (buf_full),
    .txi      (txi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (txi === 1'b1) txi_cnt <= txi_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one external bit: 4-cycle low, hi-cycle high; receiver samples at the rise
  task automatic clk_bit(input int hi, input bit do_wr, input logic [7:0] wb, output logic b);
    @(negedge clk) ext_sclk = 1'b0;
    @(negedge clk) if (do_wr) begin wr_en = 1'b1; wr_data = wb; end
    @(negedge clk) wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk) begin b = tx_out; ext_sclk = 1'b1; end
    repeat (hi - 1) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic       b;
    int         base;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ext_sclk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx_out in reset", tx_out, 1);
    chk("R1 buf_full in reset", buf_full, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 tx_out after reset", tx_out, 1);
    chk("R1 buf_full after reset", buf_full, 0);
    chk("R1 txi after reset", txi, 0);

    // R2: write timing and idle transfer of the first byte
    wr_en = 1'b1; wr_data = VEC[0][10:3];
    @(negedge clk) wr_en = 1'b0;
    chk("R2 full after write", buf_full, 1);
    chk("R2 no txi yet", txi, 0);
    @(negedge clk);
    chk("R2 full cleared by transfer", buf_full, 0);
    chk("R9 txi on transfer", txi, 1);
    @(negedge clk);
    chk("R9 txi one cycle", txi, 0);
    repeat (2) @(negedge clk);

    // table-driven back-to-back stream (R4, R5, R6)
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 8; i++) begin
        clk_bit(4, (k < 5) && (i == int'(VEC[(k < 5) ? k + 1 : k][2:0])),
                VEC[(k < 5) ? k + 1 : k][10:3], b);
        rx[i] = b;
      end
      chk((k == 0) ? "R4 first frame LSB first" :
          (VEC[k][2:0] == 3'd7) ? "R6 byte written in bit-7 low" : "R5 chained frame",
          rx, VEC[k][10:3]);
    end
    repeat (4) @(negedge clk);
    chk("R9 one txi per frame", txi_cnt, 6);
    chk("R7 register empty after stream", buf_full, 0);

    // R7: extra clocks with nothing queued
    base = txi_cnt;
    for (int i = 0; i < 8; i++) begin
      clk_bit(4, 1'b0, 8'h00, b);
      chk("R7 output holds bit 7", b, 0);
    end
    chk("R7 no txi while idle", txi_cnt, base);

    // R3 latency and R8 overwrite
    host_write(8'h33);
    repeat (3) @(negedge clk);
    base = txi_cnt;
    ext_sclk = 1'b0;
    @(negedge clk) chk("R3 unchanged one cycle after fall", tx_out, 0);
    @(negedge clk) chk("R3 unchanged two cycles after fall", tx_out, 0);
    @(negedge clk) chk("R3 new bit three cycles after fall", tx_out, 1);
    @(negedge clk) begin rx[0] = tx_out; ext_sclk = 1'b1; end
    repeat (3) @(negedge clk);
    for (int i = 1; i < 8; i++) begin
      clk_bit(4, (i == 2) || (i == 5), (i == 2) ? 8'hC3 : 8'h69, b);
      rx[i] = b;
    end
    chk("R4 frame after latency test", rx, 8'h33);
    for (int i = 0; i < 8; i++) begin
      clk_bit(4, 1'b0, 8'h00, b);
      rx[i] = b;
    end
    chk("R8 latest byte sent", rx, 8'h69);
    repeat (4) @(negedge clk);
    chk("R8 single txi for overwritten byte", txi_cnt - base, 1);
    chk("R7 idle after last frame", buf_full, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule